// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between thirteen interrupt event lines and a processor core. Each event sets a sticky pending flag. The flag stays set until software writes a zero to it. An event is eligible for service when its flag is set, its own enable is set and the global enable is on. Eligible events are sorted into six priority groups, and each group takes one of four priority levels. The level is the concatenation of one bit from a high-level register and one bit from a low-level register.

The controller picks the best eligible group and issues a registered one-cycle grant. The grant carries a vector index and the granted level. It then waits for an acknowledge before it arbitrates again. A four-bit in-service vector, with one bit per level, records which levels are being handled. A new grant must outrank every level in service, so handlers can nest up to four deep. A return pulse retires the highest level in service. Three event lines share the last group. A separate wake flag latches wake events on every occurrence and is also cleared by writing zero.

Top module: `irq_grp_prio`

## Requirements
- R1: An event on `src_evt_i[s]` sets `flag_o[s]`, which then holds until a cycle with `flag_wr_i`=1 and `flag_wdata_i[s]`=0. Writing 1 leaves it unchanged. The flag reflects the change one cycle after the input cycle.
- R2: If an event and a zero write hit the same flag in the same cycle, the flag is set afterwards.
- R3: `wake_evt_i` sets `wake_flag_o` even when it is already set. It clears only on `wake_wr_i`=1 with `wake_wdata_i`=0.
- R4: A source is eligible only when its flag, its `src_en_i` bit and `glb_en_i` are all 1. While `glb_en_i`=0 no grant is issued, but flags keep latching.
- R5: Group g has level {`prio_hi_i[g]`,`prio_lo_i[g]`}, where 0 is the lowest and 3 the highest. The eligible group with the highest level wins.
- R6: Source mapping is as follows. Sources 2g and 2g+1 belong to group g for g=0..4. Sources 10, 11 and 12 are ORed into group 5. Among equal levels the lower group index wins. Inside a group the lower source index wins. The vector is 2g+member for groups 0..4 and 10 for group 5.
- R7: A grant is issued only if its level is strictly above the highest level in `in_service_o`. A request at an equal or lower level waits.
- R8: A grant appears as `irq_valid_o`=1 for exactly one cycle, the cycle after the arbitration cycle. No further grant is issued before a cycle with `irq_ack_i`=1 that comes after the grant.
- R9: A grant sets bit `irq_lvl_o` of `in_service_o` together with `irq_valid_o`. A `reti_i` pulse clears the highest set bit one cycle later.
- R10: After reset all flags, `wake_flag_o`, `irq_valid_o` and `in_service_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | 13 | Per-source event pulses (set flags) |
| src_en_i | input | 13 | Per-source enables |
| glb_en_i | input | 1 | Global enable for arbitration |
| prio_lo_i | input | 6 | Low bit of each group's level |
| prio_hi_i | input | 6 | High bit of each group's level |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 13 | Flag write data; a 0 clears that flag |
| flag_o | output | 13 | Pending flags |
| wake_evt_i | input | 1 | Wake event pulse |
| wake_wr_i | input | 1 | Wake flag write strobe |
| wake_wdata_i | input | 1 | Wake flag write data; a 0 clears |
| wake_flag_o | output | 1 | Wake flag |
| irq_valid_o | output | 1 | One-cycle grant pulse |
| irq_vec_o | output | 4 | Granted vector index |
| irq_lvl_o | output | 2 | Granted level |
| irq_ack_i | input | 1 | Grant acknowledge |
| reti_i | input | 1 | Return-from-handler pulse |
| in_service_o | output | 4 | Levels in service, one bit per level |

## Verification
Sources are raised in pairs and triples so the bench can tell level ordering (R5) apart from fixed polling order across groups and inside a group, including the shared group (R6). Nested sequences raise lower, equal and higher levels while a handler is active. These show whether the strictly-above rule is enforced and whether a return pulse retires only the top level. A higher request raised while a grant waits for acknowledge separates the handshake hold from the level rule. Colliding set and clear writes, and events raised with the global enable off, show that no flag update is lost.

// File: rtl/irq_grp_pkg.sv
`timescale 1ns/1ps
package irq_grp_pkg;
   localparam int unsigned LVL_W = 2;
   typedef logic [LVL_W-1:0] lvl_t;
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_WAIT = 1'b1
   } arb_state_e;

   function automatic lvl_t grp_level(input logic hi, input logic lo);
      return {hi, lo};
   endfunction
endpackage

// File: rtl/irq_grp_flags.sv
`timescale 1ns/1ps
module irq_grp_flags #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] flag_o
);
   logic [WIDTH-1:0] flag_q;

   if (WIDTH < 1) begin : g_chk_width
      $error("irq_grp_flags: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
         end else if (set_i[i]) begin
            flag_q[i] <= 1'b1;
         end else if (wr_i && !wdata_i[i]) begin
            flag_q[i] <= 1'b0;
         end
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]); // R2
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !(wr_i && !wdata_i[i])) |=> flag_q[i]); // R1
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/irq_grp_gather.sv
`timescale 1ns/1ps
module irq_grp_gather #(
   parameter int unsigned NUM_GROUPS = 6,
   parameter int unsigned NUM_SRC    = 13
) (
   input  logic [NUM_SRC-1:0]    pend_i,
   output logic [NUM_GROUPS-1:0] req_o,
   output logic [NUM_GROUPS-1:0] mbr_o
);
   localparam int unsigned PAIR_N     = NUM_GROUPS - 1;
   localparam int unsigned SHARE_BASE = 2 * PAIR_N;

   if (NUM_SRC <= SHARE_BASE) begin : g_chk_src
      $error("irq_grp_gather: shared group needs at least one source");
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (g < PAIR_N) begin : g_pair
         assign req_o[g] = pend_i[2*g] | pend_i[2*g+1];
         assign mbr_o[g] = ~pend_i[2*g];
      end else begin : g_shared
         assign req_o[g] = |pend_i[NUM_SRC-1:SHARE_BASE];
         assign mbr_o[g] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_grp_pick.sv
`timescale 1ns/1ps
module irq_grp_pick
   import irq_grp_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 6,
   parameter int unsigned VEC_W      = 4
) (
   input  logic [NUM_GROUPS-1:0] req_i,
   input  logic [NUM_GROUPS-1:0] mbr_i,
   input  logic [NUM_GROUPS-1:0] prio_hi_i,
   input  logic [NUM_GROUPS-1:0] prio_lo_i,
   output logic                  hit_o,
   output logic [VEC_W-1:0]      vec_o,
   output lvl_t                  lvl_o
);
   localparam int unsigned GRP_W = $clog2(NUM_GROUPS);

   logic [GRP_W-1:0] best_grp;
   logic             best_mbr;

   if (VEC_W < GRP_W + 1) begin : g_chk_vec
      $error("irq_grp_pick: VEC_W too narrow for group and member");
   end

   // Scan downward so that a lower group index overwrites an equal level.
   always_comb begin
      hit_o    = 1'b0;
      best_grp = '0;
      best_mbr = 1'b0;
      lvl_o    = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (req_i[g] && (!hit_o || grp_level(prio_hi_i[g], prio_lo_i[g]) >= lvl_o)) begin
            hit_o    = 1'b1;
            best_grp = GRP_W'(g);
            best_mbr = mbr_i[g];
            lvl_o    = grp_level(prio_hi_i[g], prio_lo_i[g]);
         end
      end
   end

   assign vec_o = VEC_W'({best_grp, best_mbr});
endmodule

// File: rtl/irq_grp_nest.sv
`timescale 1ns/1ps
module irq_grp_nest #(
   parameter int unsigned NUM_LEVELS = 4,
   localparam int unsigned LW        = $clog2(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push_i,
   input  logic [LW-1:0]         push_lvl_i,
   input  logic                  pop_i,
   output logic [NUM_LEVELS-1:0] isr_o,
   output logic                  any_o,
   output logic [LW-1:0]         top_o
);
   logic [NUM_LEVELS-1:0] isr_q;
   logic [NUM_LEVELS-1:0] pop_mask;
   logic [NUM_LEVELS-1:0] push_mask;

   always_comb begin
      top_o = '0;
      for (int l = 0; l < NUM_LEVELS; l++) begin
         if (isr_q[l]) top_o = LW'(l);
      end
   end

   assign any_o     = |isr_q;
   assign pop_mask  = (pop_i && any_o) ? (NUM_LEVELS'(1) << top_o) : '0;
   assign push_mask = push_i ? (NUM_LEVELS'(1) << push_lvl_i) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else begin
         isr_q <= (isr_q & ~pop_mask) | push_mask;
      end
   end

   assign isr_o = isr_q;

   AST_PUSH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> isr_q[$past(push_lvl_i)]); // R9
   AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && any_o) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9
endmodule

// File: rtl/irq_grp_prio.sv
`timescale 1ns/1ps
module irq_grp_prio
   import irq_grp_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 6,
   parameter int unsigned NUM_SRC    = 13,
   parameter int unsigned NUM_LEVELS = 4,
   parameter int unsigned VEC_W      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_evt_i,
   input  logic [NUM_SRC-1:0]    src_en_i,
   input  logic                  glb_en_i,
   input  logic [NUM_GROUPS-1:0] prio_lo_i,
   input  logic [NUM_GROUPS-1:0] prio_hi_i,
   input  logic                  flag_wr_i,
   input  logic [NUM_SRC-1:0]    flag_wdata_i,
   output logic [NUM_SRC-1:0]    flag_o,
   input  logic                  wake_evt_i,
   input  logic                  wake_wr_i,
   input  logic                  wake_wdata_i,
   output logic                  wake_flag_o,
   output logic                  irq_valid_o,
   output logic [VEC_W-1:0]      irq_vec_o,
   output logic [1:0]            irq_lvl_o,
   input  logic                  irq_ack_i,
   input  logic                  reti_i,
   output logic [NUM_LEVELS-1:0] in_service_o
);
   if (NUM_LEVELS != 4) begin : g_chk_lvl
      $error("irq_grp_prio: two-register level encoding needs NUM_LEVELS == 4");
   end

   logic [NUM_SRC-1:0]    pend;
   logic [NUM_GROUPS-1:0] grp_req;
   logic [NUM_GROUPS-1:0] grp_mbr;
   logic                  win_hit;
   logic [VEC_W-1:0]      win_vec;
   lvl_t                  win_lvl;
   logic                  isr_any;
   lvl_t                  isr_top;
   logic                  fire;
   arb_state_e            state_q;

   irq_grp_flags #(.WIDTH(NUM_SRC)) u_src_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (src_evt_i),
      .wr_i    (flag_wr_i),
      .wdata_i (flag_wdata_i),
      .flag_o  (flag_o)
   );

   irq_grp_flags #(.WIDTH(1)) u_wake_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (wake_evt_i),
      .wr_i    (wake_wr_i),
      .wdata_i (wake_wdata_i),
      .flag_o  (wake_flag_o)
   );

   assign pend = flag_o & src_en_i & {NUM_SRC{glb_en_i}};

   irq_grp_gather #(.NUM_GROUPS(NUM_GROUPS), .NUM_SRC(NUM_SRC)) u_gather (
      .pend_i (pend),
      .req_o  (grp_req),
      .mbr_o  (grp_mbr)
   );

   irq_grp_pick #(.NUM_GROUPS(NUM_GROUPS), .VEC_W(VEC_W)) u_pick (
      .req_i     (grp_req),
      .mbr_i     (grp_mbr),
      .prio_hi_i (prio_hi_i),
      .prio_lo_i (prio_lo_i),
      .hit_o     (win_hit),
      .vec_o     (win_vec),
      .lvl_o     (win_lvl)
   );

   irq_grp_nest #(.NUM_LEVELS(NUM_LEVELS)) u_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (fire),
      .push_lvl_i (win_lvl),
      .pop_i      (reti_i),
      .isr_o      (in_service_o),
      .any_o      (isr_any),
      .top_o      (isr_top)
   );

   assign fire = (state_q == ARB_IDLE) && win_hit && (!isr_any || (win_lvl > isr_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ARB_IDLE;
         irq_valid_o <= 1'b0;
         irq_vec_o   <= '0;
         irq_lvl_o   <= '0;
      end else begin
         irq_valid_o <= fire;
         if (fire) begin
            irq_vec_o <= win_vec;
            irq_lvl_o <= win_lvl;
            state_q   <= ARB_WAIT;
         end else if (state_q == ARB_WAIT && irq_ack_i) begin
            state_q   <= ARB_IDLE;
         end
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |=> !irq_valid_o); // R8
   AST_HOLD_FOR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && !irq_ack_i) |=> !irq_valid_o); // R8
   AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en_i |=> !irq_valid_o); // R4
   AST_GRANT_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> ((in_service_o >> irq_lvl_o) == NUM_LEVELS'(1))); // R7
endmodule

// File: tb/irq_grp_prio_tb.sv
`timescale 1ns/1ps
module irq_grp_prio_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] src_evt = '0, src_en = '0, flag_wdata = '0;
   logic        glb_en = 1'b0, flag_wr = 1'b0;
   logic [5:0]  prio_lo = '0, prio_hi = '0;
   logic        wake_evt = 1'b0, wake_wr = 1'b0, wake_wdata = 1'b0;
   logic        irq_ack = 1'b0, reti = 1'b0;
   logic [12:0] flag;
   logic        wake_flag, irq_valid;
   logic [3:0]  irq_vec;
   logic [1:0]  irq_lvl;
   logic [3:0]  in_service;

   int n_cmp = 0, n_bad = 0;
   bit cmp_on = 1'b0, done = 1'b0;

   // reference state
   logic [12:0] m_flag = '0;
   logic        m_wake = 1'b0;
   logic [3:0]  m_isr = '0;
   logic        m_valid = 1'b0, m_wait = 1'b0;
   int          m_vec = 0, m_lvl = 0;

   always #2 clk = ~clk;

   irq_grp_prio u_dut (
      .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .src_en_i(src_en),
      .glb_en_i(glb_en), .prio_lo_i(prio_lo), .prio_hi_i(prio_hi),
      .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata), .flag_o(flag),
      .wake_evt_i(wake_evt), .wake_wr_i(wake_wr), .wake_wdata_i(wake_wdata),
      .wake_flag_o(wake_flag), .irq_valid_o(irq_valid), .irq_vec_o(irq_vec),
      .irq_lvl_o(irq_lvl), .irq_ack_i(irq_ack), .reti_i(reti),
      .in_service_o(in_service)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: behavioural, advanced on each rising edge
   always @(posedge clk) begin : ref_model
      bit found;
      int wv, wl, top;
      if (!rst_n) begin
         m_flag = '0; m_wake = 1'b0; m_isr = '0;
         m_valid = 1'b0; m_wait = 1'b0; m_vec = 0; m_lvl = 0;
      end else begin
         found = 1'b0; wv = 0; wl = 0;
         for (int lv = 3; lv >= 0; lv--) begin
            for (int g = 0; g < 6; g++) begin
               if (!found && (int'(prio_hi[g]) * 2 + int'(prio_lo[g])) == lv) begin
                  for (int s = 2 * g; s <= ((g < 5) ? 2 * g + 1 : 12); s++) begin
                     if (!found && m_flag[s] && src_en[s] && glb_en) begin
                        found = 1'b1;
                        wv = (g < 5) ? s : 10;
                        wl = lv;
                     end
                  end
               end
            end
         end
         top = -1;
         for (int l = 0; l < 4; l++) if (m_isr[l]) top = l;
         if (reti && top >= 0) m_isr[top] = 1'b0;
         m_valid = !m_wait && found && (wl > top);
         if (m_valid) begin
            m_isr[wl] = 1'b1;
            m_vec = wv; m_lvl = wl; m_wait = 1'b1;
         end else if (m_wait && irq_ack) begin
            m_wait = 1'b0;
         end
         for (int s = 0; s < 13; s++) begin
            if (src_evt[s]) m_flag[s] = 1'b1;
            else if (flag_wr && !flag_wdata[s]) m_flag[s] = 1'b0;
         end
         if (wake_evt) m_wake = 1'b1;
         else if (wake_wr && !wake_wdata) m_wake = 1'b0;
      end
   end

   // per-cycle comparison, midway between rising edges
   always @(negedge clk) begin
      if (cmp_on) begin
         check("R1 flags", int'(flag), int'(m_flag));
         check("R3 wake flag", int'(wake_flag), int'(m_wake));
         check("R8 valid", int'(irq_valid), int'(m_valid));
         check("R9 in_service", int'(in_service), int'(m_isr));
         if (m_valid) begin
            check("R6 vector", int'(irq_vec), m_vec);
            check("R5 level", int'(irq_lvl), m_lvl);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic pulse(input logic [12:0] m);
      src_evt = m; tick(1); src_evt = '0;
   endtask

   task automatic ack_it();
      irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
   endtask

   task automatic retire();
      flag_wr = 1'b1; flag_wdata = '0; reti = 1'b1;
      tick(1);
      flag_wr = 1'b0; reti = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1; cmp_on = 1'b1;
      check("R10 flags", int'(flag), 0);
      check("R10 wake", int'(wake_flag), 0);
      check("R10 valid", int'(irq_valid), 0);
      check("R10 in_service", int'(in_service), 0);
      glb_en = 1'b1;

      // R1: sticky flag, write 1 ignored, write 0 clears
      pulse(13'h0008);
      check("R1 set", int'(flag[3]), 1);
      flag_wr = 1'b1; flag_wdata = '1; tick(1);
      check("R1 write one", int'(flag[3]), 1);
      flag_wdata = ~13'h0008; tick(1); flag_wr = 1'b0;
      check("R1 write zero", int'(flag[3]), 0);

      // R2: set beats same-cycle clear
      src_evt = 13'h0020; flag_wr = 1'b1; flag_wdata = '0; tick(1);
      src_evt = '0; flag_wr = 1'b0;
      check("R2 set wins", int'(flag[5]), 1);
      flag_wr = 1'b1; tick(1); flag_wr = 1'b0;

      // R3: wake flag
      wake_evt = 1'b1; tick(1); check("R3 wake set", int'(wake_flag), 1);
      tick(1); wake_evt = 1'b0; check("R3 wake again", int'(wake_flag), 1);
      wake_wr = 1'b1; wake_wdata = 1'b1; tick(1);
      check("R3 write one", int'(wake_flag), 1);
      wake_wdata = 1'b0; tick(1); wake_wr = 1'b0;
      check("R3 write zero", int'(wake_flag), 0);

      // R4: global mask
      src_en = '1; glb_en = 1'b0;
      pulse(13'h0001);
      check("R4 flag latches", int'(flag[0]), 1);
      for (int i = 0; i < 4; i++) begin
         tick(1); check("R4 masked", int'(irq_valid), 0);
      end
      glb_en = 1'b1; tick(1);
      check("R4 unmasked valid", int'(irq_valid), 1);
      check("R4 unmasked vec", int'(irq_vec), 0);
      ack_it(); retire();
      check("R9 retired", int'(in_service), 0);

      // R5: level beats index
      prio_hi = 6'b000100; prio_lo = 6'b000101;
      pulse(13'h0011); tick(1);
      check("R5 valid", int'(irq_valid), 1);
      check("R5 vec", int'(irq_vec), 4);
      check("R5 lvl", int'(irq_lvl), 3);
      check("R9 isr", int'(in_service), 8);
      ack_it();
      for (int i = 0; i < 3; i++) begin
         tick(1); check("R7 lower waits", int'(irq_valid), 0);
      end
      flag_wr = 1'b1; flag_wdata = ~13'h0010; reti = 1'b1; tick(1);
      flag_wr = 1'b0; reti = 1'b0;
      check("R9 reti clears", int'(in_service), 0);
      tick(1);
      check("R5 second valid", int'(irq_valid), 1);
      check("R5 second vec", int'(irq_vec), 0);
      check("R5 second lvl", int'(irq_lvl), 1);
      ack_it(); retire();

      // R6: polling order
      prio_hi = '0; prio_lo = '0;
      pulse(13'h000A); tick(1);
      check("R6 lower group", int'(irq_vec), 1);
      ack_it(); retire();
      pulse(13'h000C); tick(1);
      check("R6 first member", int'(irq_vec), 2);
      ack_it(); retire();
      pulse(13'h1000); tick(1);
      check("R6 shared sub", int'(irq_vec), 10);
      ack_it(); retire();
      pulse(13'h0A00); tick(1);
      check("R6 group4 over group5", int'(irq_vec), 9);
      ack_it(); retire();

      // R7/R9: nesting
      prio_lo = 6'b000010; prio_hi = 6'b001000;
      pulse(13'h0004); tick(1);
      check("R7 first vec", int'(irq_vec), 2);
      check("R9 isr lvl1", int'(in_service), 2);
      ack_it();
      pulse(13'h0009);
      for (int i = 0; i < 3; i++) begin
         tick(1); check("R7 equal/lower waits", int'(irq_valid), 0);
      end
      pulse(13'h0040); tick(1);
      check("R7 higher preempts", int'(irq_valid), 1);
      check("R7 vec", int'(irq_vec), 6);
      check("R9 nested isr", int'(in_service), 6);
      ack_it();
      flag_wr = 1'b1; flag_wdata = ~13'h0040; reti = 1'b1; tick(1);
      flag_wr = 1'b0; reti = 1'b0;
      check("R9 pop top only", int'(in_service), 2);
      tick(2); check("R7 still blocked", int'(irq_valid), 0);
      retire();
      check("R9 empty", int'(in_service), 0);
      tick(1);

      // R8: one-cycle pulse, hold until ack
      prio_hi = 6'b010000; prio_lo = 6'b010000;
      pulse(13'h0001); tick(1);
      check("R8 grant", int'(irq_valid), 1);
      tick(1); check("R8 one cycle", int'(irq_valid), 0);
      pulse(13'h0100);
      for (int i = 0; i < 3; i++) begin
         tick(1); check("R8 awaits ack", int'(irq_valid), 0);
      end
      ack_it(); tick(1);
      check("R8 after ack", int'(irq_valid), 1);
      check("R8 vec", int'(irq_vec), 8);
      check("R9 isr two", int'(in_service), 9);
      ack_it(); retire();
      check("R9 pop level3", int'(in_service), 1);
      reti = 1'b1; tick(1); reti = 1'b0;
      check("R9 pop level0", int'(in_service), 0);
      tick(3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule